// File: doc/BRIEF.md
# Receive PLL Relock Sequencer

This controller sits in the byte-clock domain next to a serial transceiver and decides when the receive clock-recovery PLL has to be retrained. It drives an active-low lock-to-reference control. While that control is low, the recovery PLL trains on the local transmit byte clock and not on the line. Training on the local clock first stops a PLL that drifted while the line was quiet from settling on a harmonic of the incoming rate.

After a reference interval set by a parameter, the control is released and the incoming stream drives the PLL. The block then waits out the phase-lock interval, during which received words are not trusted. After that it hunts for a K28.5 comma in either 10-bit half of the 20-bit receive word. The first comma found declares receive data valid.

The lock is dropped, and a new training cycle starts, on any of three events: loss of the signal-present flag, a comma hunt that runs out of time, or a run of undecodable 10-bit codes while in sync. All timers count byte-clock cycles. The defaults are 26 596 cycles of reference training and 6 383 cycles in the short variant, 125 cycles of phase-lock wait, a 1024-cycle hunt window and a run of 4 bad words.

Top module: `rx_relock_seq`

## Requirements
- R1: A synchronous reset puts the block in reference training: `lock_ref_n` = 0, `rx_valid` = 0, `status` = 0.
- R2: In reference training (`status` 0), `lock_ref_n` stays low for exactly REF_CYCLES cycles. REF_CYCLES is REF_SHORT when SHORT_REF = 1 and REF_LONG otherwise. Then `lock_ref_n` goes high and `status` becomes 1 (settling).
- R3: Settling lasts exactly SETTLE_CYCLES cycles with `lock_ref_n` high. Commas seen during settling are ignored. Settling then moves to the comma hunt (`status` 2).
- R4: A 10-bit half holds a K28.5 comma when it equals 10'h17C or 10'h283. The half in bits 9:0 goes first on the line, and each half carries its first-sent bit in its least significant position. A comma in either half during the hunt gives `status` 3 and `rx_valid` = 1 on the next cycle.
- R5: If no comma arrives within HUNT_CYCLES cycles of entering the hunt, the block enters code loss (`status` 5, `lock_ref_n` = 0) for one cycle. It then returns to reference training. A comma in the last hunt cycle still reaches sync.
- R6: A 10-bit half is invalid when it has fewer than 4 or more than 6 ones. A word is bad when either half is invalid. In sync, BAD_LIMIT consecutive bad words cause code loss (`status` 5, `rx_valid` = 0). Any good word clears the run.
- R7: When `sig_present` is low, the next cycle from any state shows signal loss: `status` 4, `lock_ref_n` = 0, `rx_valid` = 0. The block stays there while the flag is low. One cycle after the flag returns, it restarts a full reference interval.
- R8: `rx_valid` is high only in sync. `lock_ref_n` is high only in settling, hunt and sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word | input | WORD_W | Parallel receive word, two 10-bit characters |
| sig_present | input | 1 | High while an incoming signal is detected |
| lock_ref_n | output | 1 | Active-low command to train the recovery PLL on the local clock |
| rx_valid | output | 1 | Receive data may be trusted |
| status | output | 3 | Sequencer state: 0 ref, 1 settle, 2 hunt, 3 sync, 4 signal loss, 5 code loss |

## Verification
The assertions check on every cycle that:
- valid data never coexists with reference training;
- sync is entered only from the hunt with a comma present;
- a dropped signal flag forces signal loss on the next cycle;
- a fall of `rx_valid` with the signal present can only be code loss;
- every release of `lock_ref_n` follows at least a full reference interval.

Some properties need the bench's sweeps because they depend on exact window lengths:
- the exact reference, settling and hunt durations;
- the boundary where a comma in the last hunt cycle still wins;
- the count of consecutive bad words, with fillers at the 4- and 6-ones limits;
- both comma forms in both halves.

// File: rtl/relock_pkg.sv
package relock_pkg;
  typedef enum logic [2:0] {
    ST_REF       = 3'd0,
    ST_SETTLE    = 3'd1,
    ST_HUNT      = 3'd2,
    ST_SYNC      = 3'd3,
    ST_LOST_SIG  = 3'd4,
    ST_LOST_CODE = 3'd5
  } relock_state_t;

  // K28.5 in both disparities, first-sent bit in bit 0
  localparam logic [9:0] COMMA_NEG = 10'h17C;
  localparam logic [9:0] COMMA_POS = 10'h283;
  localparam int         SYM_W     = 10;
endpackage

// File: rtl/relock_code_check.sv
module relock_code_check
  import relock_pkg::*;
#(
  parameter int HALVES = 2
) (
  input  logic [HALVES*SYM_W-1:0] word,
  output logic                    comma_hit,
  output logic                    word_bad
);
  logic [HALVES-1:0] comma_vec;
  logic [HALVES-1:0] bad_vec;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [SYM_W-1:0] sym;
    int               ones;
    assign sym  = word[h*SYM_W +: SYM_W];
    assign ones = $countones(sym);
    assign comma_vec[h] = (sym == COMMA_NEG) || (sym == COMMA_POS);
    assign bad_vec[h]   = (ones < 4) || (ones > 6);
  end

  assign comma_hit = |comma_vec;
  assign word_bad  = |bad_vec;
endmodule

// File: rtl/relock_timer.sv
module relock_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = limit - {{(CW-1){1'b0}}, 1'b1};
  assign done = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (!done)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rx_relock_seq.sv
module rx_relock_seq
  import relock_pkg::*;
#(
  parameter int REF_LONG      = 26596,
  parameter int REF_SHORT     = 6383,
  parameter bit SHORT_REF     = 1'b0,
  parameter int SETTLE_CYCLES = 125,
  parameter int HUNT_CYCLES   = 1024,
  parameter int BAD_LIMIT     = 4,
  parameter int WORD_W        = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              sig_present,
  output logic              lock_ref_n,
  output logic              rx_valid,
  output logic [2:0]        status
);
  localparam int HALVES     = WORD_W / SYM_W;
  localparam int REF_CYCLES = SHORT_REF ? REF_SHORT : REF_LONG;
  localparam int MAX_A      = (REF_CYCLES > SETTLE_CYCLES) ? REF_CYCLES : SETTLE_CYCLES;
  localparam int MAXC       = (MAX_A > HUNT_CYCLES) ? MAX_A : HUNT_CYCLES;
  localparam int CW         = $clog2(MAXC + 1);
  localparam int BW         = $clog2(BAD_LIMIT + 1);

  relock_state_t state, nxt;
  logic          comma_hit, word_bad, t_done, restart;
  logic [CW-1:0] limit;
  logic [BW-1:0] bad_run;

  relock_code_check #(.HALVES(HALVES)) u_code (
    .word(rx_word), .comma_hit(comma_hit), .word_bad(word_bad)
  );

  relock_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .limit(limit), .done(t_done)
  );

  always_comb begin
    case (state)
      ST_REF:    limit = CW'(REF_CYCLES);
      ST_SETTLE: limit = CW'(SETTLE_CYCLES);
      ST_HUNT:   limit = CW'(HUNT_CYCLES);
      default:   limit = CW'(1);
    endcase
  end

  always_comb begin
    nxt = state;
    if (!sig_present) nxt = ST_LOST_SIG;
    else begin
      case (state)
        ST_REF:       if (t_done) nxt = ST_SETTLE;
        ST_SETTLE:    if (t_done) nxt = ST_HUNT;
        ST_HUNT:      if (comma_hit) nxt = ST_SYNC;
                      else if (t_done) nxt = ST_LOST_CODE;
        ST_SYNC:      if (word_bad && bad_run == BW'(BAD_LIMIT - 1)) nxt = ST_LOST_CODE;
        ST_LOST_SIG:  nxt = ST_REF;
        ST_LOST_CODE: nxt = ST_REF;
        default:      nxt = ST_REF;
      endcase
    end
  end

  assign restart = (nxt != state);

  always_ff @(posedge clk) begin
    if (rst || state != ST_SYNC) bad_run <= '0;
    else if (word_bad)           bad_run <= bad_run + 1'b1;
    else                         bad_run <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_REF;
      lock_ref_n <= 1'b0;
      rx_valid   <= 1'b0;
      status     <= ST_REF;
    end else begin
      state      <= nxt;
      lock_ref_n <= (nxt == ST_SETTLE) || (nxt == ST_HUNT) || (nxt == ST_SYNC);
      rx_valid   <= (nxt == ST_SYNC);
      status     <= nxt;
    end
  end

  // Checker support: length of the current low run of lock_ref_n
  logic [CW-1:0] ref_run;
  always_ff @(posedge clk) begin
    if (rst || lock_ref_n)               ref_run <= '0;
    else if (ref_run != CW'(REF_CYCLES)) ref_run <= ref_run + 1'b1;
  end

  assert_ref_span_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_ref_n) |-> ref_run >= CW'(REF_CYCLES));

  assert_valid_released_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> lock_ref_n);

  assert_sync_from_hunt_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> ($past(status) == ST_HUNT) && $past(comma_hit));

  assert_sig_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !sig_present |=> (status == ST_LOST_SIG) && !rx_valid && !lock_ref_n);

  assert_code_loss_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_valid) && $past(sig_present)) |-> status == ST_LOST_CODE);

  assert_loss_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (status == ST_LOST_CODE) |=> (status == ST_REF) || (status == ST_LOST_SIG));
endmodule

// File: tb/rx_relock_seq_bench.sv
module rx_relock_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF_S  = 12;
  localparam int SETTLE = 6;
  localparam int HUNT   = 10;
  localparam int BAD    = 3;
  localparam logic [9:0] FILL  = 10'h155;
  localparam logic [9:0] FILL4 = 10'h0F0;
  localparam logic [9:0] FILL6 = 10'h3F0;
  localparam logic [9:0] BAD3  = 10'h007;
  localparam logic [9:0] BAD7  = 10'h3F8;
  localparam logic [9:0] KNEG  = 10'h17C;
  localparam logic [9:0] KPOS  = 10'h283;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] rx_word = {FILL, FILL};
  logic        sig_present = 1'b1;
  logic        lock_ref_n, rx_valid;
  logic [2:0]  status;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_relock_seq #(
    .REF_LONG(40), .REF_SHORT(REF_S), .SHORT_REF(1'b1),
    .SETTLE_CYCLES(SETTLE), .HUNT_CYCLES(HUNT), .BAD_LIMIT(BAD), .WORD_W(20)
  ) u_rx_relock_seq (
    .clk(clk), .rst(rst), .rx_word(rx_word), .sig_present(sig_present),
    .lock_ref_n(lock_ref_n), .rx_valid(rx_valid), .status(status)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic outs(input string tag, input int st, input int lk, input int vl);
    chk({tag, " status"}, int'(status), st);
    chk({tag, " lock_ref_n"}, int'(lock_ref_n), lk);
    chk({tag, " rx_valid"}, int'(rx_valid), vl);
  endtask

  task automatic do_reset();
    rst = 1'b1; sig_present = 1'b1; rx_word = {FILL, FILL};
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic reach_hunt();
    do_reset();
    outs("R1 reset", 0, 0, 0);
    repeat (REF_S - 1) tick();
    outs("R2 ref end", 0, 0, 0);
    tick();
    outs("R2 release", 1, 1, 0);
    rx_word = {KNEG, KPOS};
    repeat (SETTLE - 1) tick();
    outs("R3 settle ignores comma", 1, 1, 0);
    tick();
    outs("R3 hunt entry R8", 2, 1, 0);
    rx_word = {FILL, FILL};
  endtask

  task automatic reach_sync();
    reach_hunt();
    rx_word = {FILL, KNEG};
    tick();
    outs("R4 sync", 3, 1, 1);
    rx_word = {FILL, FILL};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R4: both comma forms, both halves, every hunt offset
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < HUNT; k++) begin
        logic [9:0] sym;
        reach_hunt();
        repeat (k) tick();
        chk("R5 no early timeout", int'(status), 2);
        sym = c[1] ? KPOS : KNEG;
        rx_word = c[0] ? {sym, FILL} : {FILL, sym};
        tick();
        outs("R4 comma found", 3, 1, 1);
        rx_word = {FILL, FILL};
        tick();
        outs("R4 sync holds", 3, 1, 1);
      end
    end

    // R5: hunt timeout then relock
    reach_hunt();
    repeat (HUNT - 1) tick();
    chk("R5 last hunt cycle", int'(status), 2);
    tick();
    outs("R5 code loss", 5, 0, 0);
    tick();
    outs("R5 back to ref", 0, 0, 0);
    repeat (REF_S - 1) tick();
    chk("R2 relock span", int'(lock_ref_n), 0);
    tick();
    outs("R2 relock release", 1, 1, 0);

    // R6: bad-word runs in either half
    for (int n = 1; n < BAD; n++) begin
      for (int h = 0; h < 2; h++) begin
        reach_sync();
        rx_word = h ? {BAD7, FILL} : {FILL, BAD3};
        repeat (n) tick();
        outs("R6 short run", 3, 1, 1);
        rx_word = {FILL6, FILL4};
        tick();
        outs("R6 good clears", 3, 1, 1);
        rx_word = h ? {BAD7, FILL} : {FILL, BAD3};
        repeat (BAD - 1) tick();
        outs("R6 below limit", 3, 1, 1);
        tick();
        outs("R6 code loss", 5, 0, 0);
        rx_word = {FILL, FILL};
        tick();
        chk("R6 to ref", int'(status), 0);
      end
    end

    // R7: signal loss from each working state
    for (int p = 0; p < 4; p++) begin
      if (p == 3) reach_sync();
      else begin
        do_reset();
        if (p == 0) repeat (3) tick();
        else if (p == 1) repeat (REF_S + 2) tick();
        else repeat (REF_S + SETTLE + 1) tick();
        chk("R7 pre-drop state", int'(status), p);
      end
      sig_present = 1'b0;
      rx_word = {KNEG, KNEG};
      tick();
      outs("R7 signal loss", 4, 0, 0);
      repeat (3) tick();
      outs("R7 loss held", 4, 0, 0);
      sig_present = 1'b1;
      rx_word = {FILL, FILL};
      tick();
      outs("R7 to ref", 0, 0, 0);
      repeat (REF_S - 1) tick();
      chk("R7 full ref", int'(status), 0);
      tick();
      outs("R7 released", 1, 1, 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule